// File: doc/BRIEF.md
# Cipher Engine Control Sequencer

This block is the control and status sequencer of a block-cipher accelerator. Software configures it through a small word-addressed register port: key-length/direction, chaining mode, a DMA-style working flag, data and authenticated-data block counts and an interrupt enable. A write-only command word carries four strobes: go, resume, leave and interrupt acknowledge. The cipher datapath is outside the block. The sequencer drives it with a one-cycle start pulse, tags blocks that carry authenticated data, and listens for a one-cycle completion pulse.

In direct style, one go launches exactly one block, and the sequencer drops back to idle as soon as that block completes. In DMA style, it launches the programmed number of blocks back to back and then parks in a done state until software writes the leave strobe. The interrupt fires only in DMA style.

GCM runs in DMA style differ in two ways. The authenticated-data blocks go first. The sequencer then holds busy until the resume strobe arrives, and only after that launches the data blocks.

Top module: `cipher_seq`

## Requirements
- R1: Status word (address 7) bits [1:0] read 0 when idle, 1 when busy and 2 when done; the value 3 never appears. After reset the state is idle and irq_o is low.
- R2: A go strobe (command word, address 6, bit 0) while idle with a valid configuration moves the state to busy on the next edge, and dp_start_o pulses while busy.
- R3: The command word is write-only and always reads 0.
- R4: Direct style (address 2 bit 0 = 0) issues exactly one dp_start_o per go. The state is idle in the cycle after dp_done_i, and irq_o never rises.
- R5: DMA style (address 2 bit 0 = 1) issues as many dp_start_o pulses as the data count (address 3), then stays in done until a leave strobe (command bit 2) returns it to idle.
- R6: On DMA completion, irq_o (mirrored in status bit 2) is set only if the enable (address 5 bit 0) is 1. The acknowledge strobe (command bit 3) clears it.
- R7: A go with a mode field (address 0, [2:0]) whose low two bits are 3, or a chaining field (address 1, [2:0]) equal to 7, leaves the state idle, with no start pulse and no interrupt.
- R8: A go strobe while busy or done is ignored: the start count and the state are unchanged.
- R9: In DMA style with chaining 6 (GCM), the authenticated-data blocks (count at address 4) are launched first with dp_aad_o high. The state then stays busy with no starts until a resume strobe (command bit 1), after which the data blocks run.
- R10: A resume strobe outside the GCM pause has no effect; a later GCM run still pauses.
- R11: The configuration registers at addresses 0 to 5 read back what was written, truncated to their widths (3, 3, 1, 32, 32, 1 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |
| dp_start_o | output | 1 | One-cycle launch pulse to the datapath |
| dp_aad_o | output | 1 | Marks the launched block as authenticated data |
| dp_done_i | input | 1 | One-cycle completion pulse from the datapath |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions check on every cycle that the state encoding stays legal and that start pulses occur only while busy, never during the GCM pause. They also check that the command word reads 0, that the done state is held until leave, and that the interrupt rises only in DMA style with the enable set. Block counts, the ordering of authenticated-data blocks before data blocks, the timing of the return to idle after a direct block, and the ignoring of stray go and resume strobes can only be shown by the bench's scenarios against its datapath model.

// File: rtl/cipher_seq.sv
module cipher_seq #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              dp_start_o,
  output logic              dp_aad_o,
  input  logic              dp_done_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CHAIN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DMA   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_NDAT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_NAAD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(7);
  localparam logic [2:0] CHAIN_GCM = 3'd6;
  localparam logic [2:0] CHAIN_RSV = 3'd7;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2} st_e;

  logic [2:0]        mode_q, chain_q;
  logic              dma_q, ien_q;
  logic [DATA_W-1:0] ndat_q, naad_q;

  st_e               st_q;
  logic              run_dma_q, run_gcm_q, inflight_q, hold_q, resumed_q;
  logic [DATA_W-1:0] aad_rem_q, dat_rem_q;
  logic              start_q, aad_q, pend_q;

  logic wr_cmd, go, resume, leave, ack;
  assign wr_cmd = wr_en && (wr_addr == A_CMD);
  assign go     = wr_cmd && wr_data[0];
  assign resume = wr_cmd && wr_data[1];
  assign leave  = wr_cmd && wr_data[2];
  assign ack    = wr_cmd && wr_data[3];

  logic cfg_ok, accept, free, pause, do_aad, do_hold, do_dat, finish;
  assign cfg_ok  = (mode_q[1:0] != 2'b11) && (chain_q != CHAIN_RSV);
  assign accept  = (st_q == ST_IDLE) && go && cfg_ok;
  assign free    = (st_q == ST_BUSY) && (!inflight_q || dp_done_i) && !hold_q;
  assign pause   = run_gcm_q && !resumed_q;
  assign do_aad  = free && (aad_rem_q != '0);
  assign do_hold = free && (aad_rem_q == '0) && pause;
  assign do_dat  = free && (aad_rem_q == '0) && !pause && (dat_rem_q != '0);
  assign finish  = free && (aad_rem_q == '0) && !pause && (dat_rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      chain_q <= '0;
      dma_q   <= 1'b0;
      ien_q   <= 1'b0;
      ndat_q  <= '0;
      naad_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode_q  <= wr_data[2:0];
        A_CHAIN: chain_q <= wr_data[2:0];
        A_DMA:   dma_q   <= wr_data[0];
        A_NDAT:  ndat_q  <= wr_data;
        A_NAAD:  naad_q  <= wr_data;
        A_IEN:   ien_q   <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      run_dma_q  <= 1'b0;
      run_gcm_q  <= 1'b0;
      inflight_q <= 1'b0;
      hold_q     <= 1'b0;
      resumed_q  <= 1'b0;
      aad_rem_q  <= '0;
      dat_rem_q  <= '0;
      start_q    <= 1'b0;
      aad_q      <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      start_q <= do_aad || do_dat;
      aad_q   <= do_aad;
      if (accept) begin
        st_q       <= ST_BUSY;
        run_dma_q  <= dma_q;
        run_gcm_q  <= dma_q && (chain_q == CHAIN_GCM);
        aad_rem_q  <= (dma_q && (chain_q == CHAIN_GCM)) ? naad_q : '0;
        dat_rem_q  <= dma_q ? ndat_q : DATA_W'(1);
        inflight_q <= 1'b0;
        hold_q     <= 1'b0;
        resumed_q  <= 1'b0;
      end
      if (do_aad) begin
        aad_rem_q  <= aad_rem_q - 1'b1;
        inflight_q <= 1'b1;
      end
      if (do_dat) begin
        dat_rem_q  <= dat_rem_q - 1'b1;
        inflight_q <= 1'b1;
      end
      if (do_hold) begin
        hold_q     <= 1'b1;
        inflight_q <= 1'b0;
      end
      if (finish) begin
        inflight_q <= 1'b0;
        st_q       <= run_dma_q ? ST_DONE : ST_IDLE;
      end
      if (hold_q && resume) begin
        hold_q    <= 1'b0;
        resumed_q <= 1'b1;
      end
      if ((st_q == ST_DONE) && leave) st_q <= ST_IDLE;
      if (finish && run_dma_q && ien_q) pend_q <= 1'b1;
      else if (ack)                     pend_q <= 1'b0;
    end
  end

  assign dp_start_o = start_q;
  assign dp_aad_o   = aad_q;
  assign irq_o      = pend_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE:  rd_data[2:0] = mode_q;
      A_CHAIN: rd_data[2:0] = chain_q;
      A_DMA:   rd_data[0]   = dma_q;
      A_NDAT:  rd_data      = ndat_q;
      A_NAAD:  rd_data      = naad_q;
      A_IEN:   rd_data[0]   = ien_q;
      A_STAT:  rd_data[2:0] = {pend_q, st_q};
      default: rd_data      = '0;
    endcase
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) st_q != 2'd3); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) dp_start_o |-> st_q == ST_BUSY); // R2
  AST_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_addr == A_CMD |-> rd_data == '0); // R3
  AST_DONE_DMA: assert property (@(posedge clk) disable iff (!rst_n) st_q == ST_DONE |-> run_dma_q); // R4
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_DONE) && !leave |=> st_q == ST_DONE); // R5
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_o) |-> ien_q && run_dma_q); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) hold_q |-> !dp_start_o && st_q == ST_BUSY); // R9
endmodule

// File: tb/cipher_seq_tb.sv
module cipher_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 5;
  // columns: mode, chain, data blocks, irq enable
  localparam int VTAB [NV][4] = '{
    '{0, 0, 4, 1},
    '{1, 1, 1, 1},
    '{2, 3, 7, 0},
    '{4, 5, 0, 1},
    '{6, 2, 3, 0}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, dp_done = 0;
  logic [2:0] wr_addr = 0, rd_addr = 3'd7;
  logic [31:0] wr_data = 0, rd_data;
  logic dp_start, dp_aad, irq;
  int checks = 0, errors = 0, starts = 0, aad_starts = 0, cd = 0;

  always #(CLK_P/2) clk = ~clk;

  cipher_seq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dp_start_o(dp_start),
    .dp_aad_o(dp_aad), .dp_done_i(dp_done), .irq_o(irq));

  always @(negedge clk) begin
    dp_done = 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) dp_done = 1'b1;
    end
    if (dp_start) begin
      starts = starts + 1;
      if (dp_aad) aad_starts = aad_starts + 1;
      cd = 3;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data; rd_addr = 3'd7;
  endtask

  task automatic wait_st(input logic [1:0] s);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (rd_data[1:0] == s) break;
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #(CLK_P*3); rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset state", rd_data, 0);
    chk("R1 reset irq", irq, 0);

    wr(0, 32'hFFFF_FFFD); wr(1, 5); wr(3, 32'hDEAD_BEEF); wr(4, 32'h1234_5678); wr(5, 3);
    rd(0, v); chk("R11 mode", v, 5);
    rd(1, v); chk("R11 chain", v, 5);
    rd(3, v); chk("R11 data count", v, 32'hDEAD_BEEF);
    rd(4, v); chk("R11 aad count", v, 32'h1234_5678);
    rd(5, v); chk("R11 irq enable", v, 1);
    wr(6, 0);
    rd(6, v); chk("R3 command reads zero", v, 0);

    // direct style, single block
    wr(0, 0); wr(1, 6); wr(2, 0); wr(3, 9); wr(5, 1);
    starts = 0;
    @(negedge clk); wr_en = 1; wr_addr = 6; wr_data = 1;
    @(negedge clk); wr_en = 0; #1;
    chk("R2 busy after go", rd_data[1:0], 1);
    do @(posedge clk); while (dp_done !== 1'b1);
    @(negedge clk); #1;
    chk("R4 idle cycle after done", rd_data[1:0], 0);
    idle_cycles(10);
    chk("R4 one start per go", starts, 1);
    chk("R4 no irq in direct", irq, 0);

    // DMA runs from the vector table
    wr(2, 1);
    for (int k = 0; k < NV; k++) begin
      wr(0, VTAB[k][0]); wr(1, VTAB[k][1]); wr(3, VTAB[k][2]); wr(5, VTAB[k][3]);
      starts = 0;
      wr(6, 1);
      wait_st(2);
      chk("R5 done state", rd_data[1:0], 2);
      chk("R5 start count", starts, VTAB[k][2]);
      chk("R6 irq follows enable", irq, VTAB[k][3]);
      idle_cycles(5);
      chk("R5 done held", rd_data[1:0], 2);
      wr(6, 4); #1;
      chk("R5 leave to idle", rd_data[1:0], 0);
      chk("R6 irq kept after leave", irq, VTAB[k][3]);
      wr(6, 8); #1;
      chk("R6 ack clears irq", irq, 0);
    end

    // reserved configurations
    wr(0, 3); wr(1, 0); starts = 0; wr(6, 1); idle_cycles(10);
    chk("R7 mode 3 idle", rd_data[2:0], 0);
    chk("R7 mode 3 no start", starts, 0);
    wr(0, 7); idle_cycles(1); wr(6, 1); idle_cycles(10);
    chk("R7 mode 7 idle", rd_data[2:0], 0);
    wr(0, 4); wr(1, 7); wr(6, 1); idle_cycles(10);
    chk("R7 chain 7 idle", rd_data[2:0], 0);
    chk("R7 chain 7 no start", starts, 0);

    // go while busy and while done
    wr(1, 1); wr(3, 6); wr(5, 0); starts = 0;
    wr(6, 1); idle_cycles(3); wr(6, 1);
    wait_st(2);
    chk("R8 go while busy ignored", starts, 6);
    wr(6, 1); idle_cycles(10);
    chk("R8 go while done ignored", rd_data[1:0], 2);
    chk("R8 no extra start", starts, 6);
    wr(6, 4);

    // GCM with pause; stray resume first
    wr(1, 6); wr(3, 3); wr(4, 2); wr(5, 1);
    wr(6, 2); idle_cycles(2);
    chk("R10 resume idle no effect", rd_data[1:0], 0);
    starts = 0; aad_starts = 0;
    wr(6, 1); idle_cycles(30);
    chk("R9 paused busy", rd_data[1:0], 1);
    chk("R10 still paused", starts, 2);
    chk("R9 aad first", aad_starts, 2);
    wr(6, 2);
    wait_st(2);
    chk("R9 data after resume", starts, 5);
    chk("R9 aad count kept", aad_starts, 2);
    chk("R6 gcm irq", irq, 1);
    wr(6, 12); #1;
    chk("R5 gcm leave", rd_data[2:0], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule